// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Generator

This block produces the vertical scanline timing of a display pipe whose frame length may vary from frame to frame. A line tick input advances a scanline counter once per line. After the active region the block enters vertical blank and, when variable refresh is on, keeps blank open until software signals a push or the longest allowed frame is reached. It then runs a fixed-length exit sequence, latches its double-buffered settings and starts the next frame at line zero. When variable refresh is off, every frame has the same programmed length and the settings latch as blank begins.

Software programs the block through a simple write port with combinational read-back. The frame-timing settings are shadowed: a write lands in a pending copy, and the copy that steers the counter only changes on the latch strobe. The push register is not shadowed. Its send bit stays readable as set until the sequencer consumes the push.

The sequencer has four states. ACTIVE counts the lines of the active region. FIXBLANK is blank in fixed mode. HOLD is the stretched blank of variable refresh. EXIT is the exit sequence that runs after the decision.

The transitions, each taken on a line tick with n as the next line number, are:
- ACTIVE to FIXBLANK when n reaches the active height in fixed mode. The settings latch at this point.
- ACTIVE to HOLD when n reaches the active height in variable mode.
- HOLD to EXIT when a push is pending and n is at or past the flip boundary, or when n reaches the max boundary. The settings latch here.
- FIXBLANK to ACTIVE when n reaches the fixed frame length. The line counter returns to zero.
- EXIT to ACTIVE when n reaches the exit line plus the exit length. The line counter returns to zero.

Top module: `vrr_vtimer`

## Requirements
- R1: While reset is active and just after it, vblank, frame_start and latch_strobe are 0, cur_line is 0, and every register reads back as 0.
- R2: Register map by address: 0 control, 1 push, 2 vmin, 3 vmax, 4 flipline, 5 active height, 6 fixed length. Control bit 0 turns variable refresh on. Control bit 1 enables the flipline register. Control bits 3:2 hold the framestart delay minus one. Control bits 15:8 hold the guardband. The vmin, vmax, flipline and fixed-length registers hold a line count minus one. The active height holds the plain line count. Pending values read back exactly as written.
- R3: In fixed mode every frame is (fixed-length register + 1) lines long, and latch_strobe pulses in the cycle in which cur_line first equals the active height.
- R4: cur_line advances by one on each line tick and returns to 0 with a one-cycle frame_start pulse. vblank is 1 from the line equal to the active height until frame start.
- R5: The exit length E equals the guardband plus the framestart delay plus one, where the framestart delay is the field plus one (1 to 4). Every variable-refresh frame is the exit line plus E lines long, and latch_strobe marks the exit line.
- R6: In variable mode with no push, exit starts at line vmax − E, so the frame is exactly vmax lines long.
- R7: A push written during line p, where p lies between the flip boundary and the max boundary, starts the exit at line p + 1.
- R8: A push sent before the flip boundary is held and acted on at that boundary, giving a frame of flipline lines. With the flipline register disabled, the boundary uses vmin + 1.
- R9: Push register bit 0 is the enable and bit 1 is send. Send is set only when written together with the enable. It reads back as 1 until the exit starts, and the exit clears it.
- R10: A change to the frame-timing registers made during blank, before the exit, does not alter the current frame. It governs the frame after the next latch.
- R11: Writing 0 to the control and push registers returns the block to fixed-length frames. A push sent while in fixed mode leaves the frame length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read-back |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read-back of the addressed register (pending copy) |
| line_tick | input | 1 | One-cycle pulse per scanline |
| vblank | output | 1 | Vertical blank indicator |
| frame_start | output | 1 | One-cycle pulse when a new frame begins |
| latch_strobe | output | 1 | One-cycle pulse when the shadowed settings take effect |
| cur_line | output | LINE_W (12) | Current scanline number |

## Verification
The frame decision is tried with a range of push timings:
- no push;
- a push before the flip boundary;
- a push on the line just ahead of that boundary;
- a push in the middle of the window;
- a push on the last line before the max boundary.

This range separates the held-push path, the immediate-exit path and the timeout path, because each gives a different frame length and exit line. Different guardband and delay settings separate the exit-length terms from each other. Running the flipline register enabled and disabled shows which source sets the early boundary. Pushes sent in fixed mode and register writes made during blank show that neither input reaches the current frame.

// File: rtl/vrr_pkg.sv
package vrr_pkg;

    localparam int unsigned REG_ADDR_W = 3;

    // register addresses; line registers are contiguous from ADDR_LINE0
    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_PUSH  = 3'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_LINE0 = 3'd2;

    localparam int unsigned N_LINE_REGS = 5;
    localparam int unsigned LR_VMIN = 0;
    localparam int unsigned LR_VMAX = 1;
    localparam int unsigned LR_FLIP = 2;
    localparam int unsigned LR_VACT = 3;
    localparam int unsigned LR_VTOT = 4;

    // control field positions
    localparam int unsigned CTL_ON_BIT   = 0;
    localparam int unsigned CTL_FLIP_BIT = 1;
    localparam int unsigned CTL_FSD_LSB  = 2;
    localparam int unsigned CTL_GB_LSB   = 8;

    // push field positions
    localparam int unsigned PSH_EN_BIT   = 0;
    localparam int unsigned PSH_SEND_BIT = 1;

    typedef enum logic [1:0] {
        ST_ACTIVE,
        ST_FIXBLANK,
        ST_HOLD,
        ST_EXIT
    } vt_state_e;

endpackage

// File: rtl/vrr_regfile.sv
module vrr_regfile
    import vrr_pkg::*;
#(
    parameter int unsigned LINE_W = 12,
    parameter int unsigned GB_W   = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  latch,
    input  logic                  push_clear,
    output logic [DATA_W-1:0]     rdata,
    output logic                  on_a,
    output logic                  flip_on_a,
    output logic [1:0]            fsd_a,
    output logic [GB_W-1:0]       gb_a,
    output logic [LINE_W-1:0]     vmin_a,
    output logic [LINE_W-1:0]     vmax_a,
    output logic [LINE_W-1:0]     flip_a,
    output logic [LINE_W-1:0]     vact_a,
    output logic [LINE_W-1:0]     vtot_a,
    output logic                  push_en,
    output logic                  push_send
);

    logic              on_p;
    logic              flip_on_p;
    logic [1:0]        fsd_p;
    logic [GB_W-1:0]   gb_p;
    logic [LINE_W-1:0] line_p [N_LINE_REGS];
    logic [LINE_W-1:0] line_a [N_LINE_REGS];

    // control register: pending and active copies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_p      <= 1'b0;
            flip_on_p <= 1'b0;
            fsd_p     <= '0;
            gb_p      <= '0;
        end else if (we && addr == ADDR_CTRL) begin
            on_p      <= wdata[CTL_ON_BIT];
            flip_on_p <= wdata[CTL_FLIP_BIT];
            fsd_p     <= wdata[CTL_FSD_LSB +: 2];
            gb_p      <= wdata[CTL_GB_LSB +: GB_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_a      <= 1'b0;
            flip_on_a <= 1'b0;
            fsd_a     <= '0;
            gb_a      <= '0;
        end else if (latch) begin
            on_a      <= on_p;
            flip_on_a <= flip_on_p;
            fsd_a     <= fsd_p;
            gb_a      <= gb_p;
        end
    end

    // line-count registers, one pending/active pair each
    for (genvar k = 0; k < N_LINE_REGS; k++) begin : g_line
        localparam logic [REG_ADDR_W-1:0] MY_ADDR = ADDR_LINE0 + REG_ADDR_W'(k);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_p[k] <= '0;
            end else if (we && addr == MY_ADDR) begin
                line_p[k] <= wdata[LINE_W-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_a[k] <= '0;
            end else if (latch) begin
                line_a[k] <= line_p[k];
            end
        end
    end

    assign vmin_a = line_a[LR_VMIN];
    assign vmax_a = line_a[LR_VMAX];
    assign flip_a = line_a[LR_FLIP];
    assign vact_a = line_a[LR_VACT];
    assign vtot_a = line_a[LR_VTOT];

    // push register: not shadowed, send consumed by the sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_en   <= 1'b0;
            push_send <= 1'b0;
        end else if (we && addr == ADDR_PUSH) begin
            push_en   <= wdata[PSH_EN_BIT];
            push_send <= wdata[PSH_EN_BIT] & wdata[PSH_SEND_BIT];
        end else if (push_clear) begin
            push_send <= 1'b0;
        end
    end

    // read-back of pending copies
    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[CTL_ON_BIT]          = on_p;
            rdata[CTL_FLIP_BIT]        = flip_on_p;
            rdata[CTL_FSD_LSB +: 2]    = fsd_p;
            rdata[CTL_GB_LSB +: GB_W]  = gb_p;
        end else if (addr == ADDR_PUSH) begin
            rdata[PSH_EN_BIT]   = push_en;
            rdata[PSH_SEND_BIT] = push_send;
        end else begin
            for (int k = 0; k < N_LINE_REGS; k++) begin
                if (addr == ADDR_LINE0 + REG_ADDR_W'(k)) begin
                    rdata[LINE_W-1:0] = line_p[k];
                end
            end
        end
    end

endmodule

// File: rtl/vrr_bounds.sv
module vrr_bounds #(
    parameter int unsigned LINE_W = 12,
    parameter int unsigned GB_W   = 8
) (
    input  logic              flip_on,
    input  logic [1:0]        fsd,
    input  logic [GB_W-1:0]   gb,
    input  logic [LINE_W-1:0] vmin_m1,
    input  logic [LINE_W-1:0] vmax_m1,
    input  logic [LINE_W-1:0] flip_m1,
    output logic [LINE_W:0]   exit_len,
    output logic [LINE_W:0]   flip_bound,
    output logic [LINE_W:0]   vmax_bound
);

    localparam int unsigned LW1 = LINE_W + 1;

    logic [LW1-1:0] flip_eff;
    logic [LW1-1:0] vmax_eff;

    // guardband + (field + 1) + 1
    assign exit_len = LW1'(gb) + LW1'(fsd) + LW1'(2);

    // earliest flip line: flipline register, or vmin + 1 when disabled
    assign flip_eff = flip_on ? (LW1'(flip_m1) + LW1'(1))
                              : (LW1'(vmin_m1) + LW1'(2));
    assign vmax_eff = LW1'(vmax_m1) + LW1'(1);

    assign flip_bound = (flip_eff > exit_len) ? (flip_eff - exit_len) : '0;
    assign vmax_bound = (vmax_eff > exit_len) ? (vmax_eff - exit_len) : '0;

endmodule

// File: rtl/vrr_seq.sv
module vrr_seq
    import vrr_pkg::*;
#(
    parameter int unsigned LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              vrr_on,
    input  logic              push_req,
    input  logic [LINE_W-1:0] vact,
    input  logic [LINE_W-1:0] vtot_m1,
    input  logic [LINE_W:0]   exit_len,
    input  logic [LINE_W:0]   flip_bound,
    input  logic [LINE_W:0]   vmax_bound,
    output logic              latch_now,
    output logic              push_clear,
    output logic              vblank,
    output logic              frame_start,
    output logic              latch_strobe,
    output logic [LINE_W-1:0] cur_line
);

    localparam int unsigned LW1 = LINE_W + 1;

    vt_state_e         state_q, state_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic [LW1-1:0]    exit_end_q, exit_end_d;
    logic [LW1-1:0]    nline;
    logic              go_exit;
    logic              fix_latch;
    logic              new_frame;

    assign nline = LW1'(line_q) + LW1'(1);

    // next state
    always_comb begin
        state_d    = state_q;
        line_d     = line_q;
        exit_end_d = exit_end_q;
        go_exit    = 1'b0;
        fix_latch  = 1'b0;
        new_frame  = 1'b0;
        if (tick) begin
            line_d = nline[LINE_W-1:0];
            unique case (state_q)
                ST_ACTIVE: begin
                    if (nline >= LW1'(vact)) begin
                        if (vrr_on) begin
                            state_d = ST_HOLD;
                        end else begin
                            state_d   = ST_FIXBLANK;
                            fix_latch = 1'b1;
                        end
                    end
                end
                ST_FIXBLANK: begin
                    if (nline > LW1'(vtot_m1)) begin
                        state_d   = ST_ACTIVE;
                        line_d    = '0;
                        new_frame = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if ((push_req && nline >= flip_bound) || nline >= vmax_bound) begin
                        state_d    = ST_EXIT;
                        go_exit    = 1'b1;
                        exit_end_d = nline + exit_len;
                    end
                end
                ST_EXIT: begin
                    if (nline >= exit_end_q) begin
                        state_d   = ST_ACTIVE;
                        line_d    = '0;
                        new_frame = 1'b1;
                    end
                end
            endcase
        end
    end

    assign latch_now  = go_exit | fix_latch;
    assign push_clear = go_exit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_ACTIVE;
            line_q     <= '0;
            exit_end_q <= '0;
        end else begin
            state_q    <= state_d;
            line_q     <= line_d;
            exit_end_q <= exit_end_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vblank       <= 1'b0;
            frame_start  <= 1'b0;
            latch_strobe <= 1'b0;
        end else begin
            vblank       <= (state_d != ST_ACTIVE);
            frame_start  <= new_frame;
            latch_strobe <= latch_now;
        end
    end

    assign cur_line = line_q;

endmodule

// File: rtl/vrr_vtimer.sv
module vrr_vtimer
    import vrr_pkg::*;
#(
    parameter int unsigned LINE_W = 12,
    parameter int unsigned GB_W   = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  line_tick,
    output logic                  vblank,
    output logic                  frame_start,
    output logic                  latch_strobe,
    output logic [LINE_W-1:0]     cur_line
);

    logic              on_a;
    logic              flip_on_a;
    logic [1:0]        fsd_a;
    logic [GB_W-1:0]   gb_a;
    logic [LINE_W-1:0] vmin_a, vmax_a, flip_a, vact_a, vtot_a;
    logic              push_en, push_send;
    logic              latch_now, push_clear;
    logic [LINE_W:0]   exit_len, flip_bound, vmax_bound;

    vrr_regfile #(
        .LINE_W (LINE_W),
        .GB_W   (GB_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .latch      (latch_now),
        .push_clear (push_clear),
        .rdata      (reg_rdata),
        .on_a       (on_a),
        .flip_on_a  (flip_on_a),
        .fsd_a      (fsd_a),
        .gb_a       (gb_a),
        .vmin_a     (vmin_a),
        .vmax_a     (vmax_a),
        .flip_a     (flip_a),
        .vact_a     (vact_a),
        .vtot_a     (vtot_a),
        .push_en    (push_en),
        .push_send  (push_send)
    );

    vrr_bounds #(
        .LINE_W (LINE_W),
        .GB_W   (GB_W)
    ) u_bounds (
        .flip_on    (flip_on_a),
        .fsd        (fsd_a),
        .gb         (gb_a),
        .vmin_m1    (vmin_a),
        .vmax_m1    (vmax_a),
        .flip_m1    (flip_a),
        .exit_len   (exit_len),
        .flip_bound (flip_bound),
        .vmax_bound (vmax_bound)
    );

    vrr_seq #(
        .LINE_W (LINE_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (line_tick),
        .vrr_on       (on_a),
        .push_req     (push_en & push_send),
        .vact         (vact_a),
        .vtot_m1      (vtot_a),
        .exit_len     (exit_len),
        .flip_bound   (flip_bound),
        .vmax_bound   (vmax_bound),
        .latch_now    (latch_now),
        .push_clear   (push_clear),
        .vblank       (vblank),
        .frame_start  (frame_start),
        .latch_strobe (latch_strobe),
        .cur_line     (cur_line)
    );

endmodule

// File: rtl/vrr_vtimer_chk.sv
module vrr_vtimer_chk #(
    parameter int unsigned LINE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_tick,
    input logic              reg_we,
    input logic              vblank,
    input logic              frame_start,
    input logic              latch_strobe,
    input logic              push_send,
    input logic [LINE_W-1:0] cur_line
);

    // R4
    frame_start_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (cur_line == '0 && !vblank));

    // R4
    frame_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R4
    vblank_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblank) |-> frame_start);

    // R4
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_line != $past(cur_line)) |-> (frame_start || cur_line == $past(cur_line) + 1'b1));

    // R4
    line_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_tick) |-> $stable(cur_line));

    // R3
    latch_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strobe |-> ($past(line_tick) && vblank));

    // R9
    send_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(push_send) |-> (latch_strobe || $past(reg_we)));

endmodule

bind vrr_vtimer vrr_vtimer_chk #(.LINE_W(LINE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_tick    (line_tick),
    .reg_we       (reg_we),
    .vblank       (vblank),
    .frame_start  (frame_start),
    .latch_strobe (latch_strobe),
    .push_send    (push_send),
    .cur_line     (cur_line)
);

// File: tb/sim_vrr_vtimer.sv
`timescale 1ns/1ps
module sim_vrr_vtimer;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_PUSH = 3'd1;
    localparam logic [2:0] A_VMIN = 3'd2;
    localparam logic [2:0] A_VMAX = 3'd3;
    localparam logic [2:0] A_FLIP = 3'd4;
    localparam logic [2:0] A_VACT = 3'd5;
    localparam logic [2:0] A_VTOT = 3'd6;
    localparam int NONE = -1;

    typedef struct packed {
        logic        flip_on;
        logic [7:0]  gb;
        logic [2:0]  fsd;
        logic [11:0] vmin;
        logic [11:0] vmax;
        logic [11:0] flip;
        logic [11:0] push_at;   // 12'hFFF: no push
        logic [11:0] exp_len;
        logic [11:0] exp_latch;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'd5,  3'd2, 12'd30, 12'd60, 12'd31, 12'hFFF, 12'd60, 12'd52},
        '{1'b1, 8'd5,  3'd2, 12'd30, 12'd60, 12'd31, 12'd40,  12'd49, 12'd41},
        '{1'b1, 8'd5,  3'd2, 12'd30, 12'd60, 12'd31, 12'd10,  12'd31, 12'd23},
        '{1'b1, 8'd5,  3'd2, 12'd30, 12'd60, 12'd31, 12'd22,  12'd31, 12'd23},
        '{1'b1, 8'd5,  3'd2, 12'd30, 12'd60, 12'd31, 12'd51,  12'd60, 12'd52},
        '{1'b1, 8'd5,  3'd2, 12'd30, 12'd60, 12'd40, 12'd10,  12'd40, 12'd32},
        '{1'b0, 8'd5,  3'd2, 12'd30, 12'd60, 12'd40, 12'd10,  12'd31, 12'd23},
        '{1'b1, 8'd0,  3'd4, 12'd30, 12'd60, 12'd31, 12'hFFF, 12'd60, 12'd55},
        '{1'b1, 8'd0,  3'd4, 12'd30, 12'd60, 12'd31, 12'd30,  12'd36, 12'd31},
        '{1'b1, 8'd10, 3'd1, 12'd30, 12'd45, 12'd31, 12'd25,  12'd38, 12'd26},
        '{1'b1, 8'd10, 3'd1, 12'd30, 12'd45, 12'd31, 12'hFFF, 12'd45, 12'd33}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        line_tick = 1'b0;
    logic        vblank, frame_start, latch_strobe;
    logic [11:0] cur_line;

    int  checks = 0;
    int  errors = 0;
    bit  tick_on = 1'b0;
    int  tcnt = 0;

    always #5 clk = ~clk;

    vrr_vtimer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .line_tick    (line_tick),
        .vblank       (vblank),
        .frame_start  (frame_start),
        .latch_strobe (latch_strobe),
        .cur_line     (cur_line)
    );

    // one line every four clocks
    initial begin
        forever begin
            @(negedge clk);
            if (tick_on) begin
                tcnt++;
                line_tick = (tcnt % 4 == 0);
            end else begin
                line_tick = 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    task automatic sync_frame();
        do @(negedge clk); while (!frame_start);
    endtask

    // called in a frame_start cycle; runs to the next frame_start
    task automatic measure(input int inj_line, input logic [2:0] inj_addr,
                           input logic [15:0] inj_data,
                           output int len, output int latch_line, output int vb_line);
        bit done = 1'b0;
        bit injected = 1'b0;
        int last = 0;
        latch_line = NONE;
        vb_line = NONE;
        while (!done) begin
            @(negedge clk);
            reg_we = 1'b0;
            if (frame_start) begin
                done = 1'b1;
            end else begin
                last = int'(cur_line);
                if (latch_strobe && latch_line == NONE) latch_line = int'(cur_line);
                if (vblank && vb_line == NONE) vb_line = int'(cur_line);
                if (!injected && inj_line != NONE && int'(cur_line) == inj_line) begin
                    reg_we = 1'b1; reg_addr = inj_addr; reg_wdata = inj_data;
                    injected = 1'b1;
                end
            end
        end
        reg_we = 1'b0;
        len = last + 1;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len, lat, vb, rv;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R1 during reset
        check("R1 vblank in reset", int'(vblank), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 vblank", int'(vblank), 0);
        check("R1 frame_start", int'(frame_start), 0);
        check("R1 latch_strobe", int'(latch_strobe), 0);
        check("R1 cur_line", int'(cur_line), 0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), rv);
            check("R1 register reset value", rv, 0);
        end

        // R2 field read-back
        wr(A_CTRL, 16'h050B);
        rd(A_CTRL, rv);
        check("R2 control read-back", rv, 16'h050B);
        wr(A_VTOT, 16'd39);
        rd(A_VTOT, rv);
        check("R2 fixed-length read-back", rv, 39);
        wr(A_CTRL, 16'h0000);
        wr(A_VACT, 16'd20);
        wr(A_PUSH, 16'h0001);

        // R3 fixed mode
        tick_on = 1'b1;
        sync_frame();
        measure(NONE, A_PUSH, 16'h0, len, lat, vb);
        measure(NONE, A_PUSH, 16'h0, len, lat, vb);
        check("R3 fixed frame length", len, 40);
        check("R3 fixed latch at blank start", lat, 20);
        check("R4 vblank start line", vb, 20);

        // R11 push ignored in fixed mode; R9 send read-back
        measure(5, A_PUSH, 16'h0003, len, lat, vb);
        check("R11 push ignored in fixed mode", len, 40);
        rd(A_PUSH, rv);
        check("R9 send reads back set", rv, 3);
        wr(A_PUSH, 16'h0001);

        // R5..R9 table of variable-refresh cases
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, {VECS[i].gb, 4'd0, 2'(VECS[i].fsd - 3'd1), VECS[i].flip_on, 1'b1});
            wr(A_VMIN, 16'(VECS[i].vmin - 12'd1));
            wr(A_VMAX, 16'(VECS[i].vmax - 12'd1));
            wr(A_FLIP, 16'(VECS[i].flip - 12'd1));
            wr(A_PUSH, 16'h0001);
            sync_frame();
            measure(NONE, A_PUSH, 16'h0, len, lat, vb);
            measure((VECS[i].push_at == 12'hFFF) ? NONE : int'(VECS[i].push_at),
                    A_PUSH, 16'h0003, len, lat, vb);
            // R6 R7 R8 frame length; R5 exit line = length - E
            check($sformatf("R5 R6 R7 R8 frame length vec %0d", i), len, int'(VECS[i].exp_len));
            check($sformatf("R5 exit line vec %0d", i), lat, int'(VECS[i].exp_latch));
            check($sformatf("R4 vblank start vec %0d", i), vb, 20);
            rd(A_PUSH, rv);
            check($sformatf("R9 send cleared vec %0d", i), rv, 1);
        end

        // R10 pending vmax written during blank
        wr(A_CTRL, 16'h0507);
        wr(A_VMIN, 16'd29);
        wr(A_VMAX, 16'd59);
        wr(A_FLIP, 16'd30);
        sync_frame();
        measure(NONE, A_PUSH, 16'h0, len, lat, vb);
        measure(30, A_VMAX, 16'd44, len, lat, vb);
        check("R10 current frame keeps old vmax", len, 60);
        measure(NONE, A_PUSH, 16'h0, len, lat, vb);
        check("R10 next frame uses new vmax", len, 45);
        check("R10 new exit line", lat, 37);

        // R11 disable
        wr(A_CTRL, 16'h0000);
        wr(A_PUSH, 16'h0000);
        sync_frame();
        measure(NONE, A_PUSH, 16'h0, len, lat, vb);
        measure(NONE, A_PUSH, 16'h0, len, lat, vb);
        check("R11 fixed length after disable", len, 40);
        check("R11 latch at blank start after disable", lat, 20);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule